// File: doc/BRIEF.md
# Wiper Register Bank with Power-Up Recall

This block is the register side of a digitally controlled potentiometer. It keeps a volatile wiper code that selects one tap of a resistor string, plus a small bank of stored presets that stand in for nonvolatile memory. A front end that has already parsed the serial bus presents one decoded command per cycle: an opcode, a preset index and a data word. The bank reads or writes the wiper code, reads or writes a preset, or moves a value between a preset and the wiper code.

Preset writes model nonvolatile programming. A hardware protect input, active low, can block them. Each accepted preset write opens a busy window of a fixed number of clock cycles, and every command that arrives during that window is dropped. When reset is released, the wiper code holds the contents of preset 0. Reset does not clear the presets. The wiper code is decoded into a registered one-hot tap-select vector, one bit per tap.

Top module: `wiper_bank`

## Requirements
- R1: `tap_sel` always has exactly one bit set. That bit is at the index equal to the `wiper_code` of the previous cycle.
- R2: Code 000h drives bit 0 of `tap_sel` (the low terminal) and code 3FFh drives bit 1023 (the high terminal).
- R3: Opcode 101 loads `cmd_data` into `wiper_code` on the accepting edge. Opcode 100 returns `wiper_code` on `rd_data` with `rd_valid` high for one cycle after that edge.
- R4: Opcode 111 writes `cmd_data` to preset `cmd_sel`. Opcode 110 returns preset `cmd_sel` on `rd_data` with `rd_valid`.
- R5: Opcode 010 copies preset `cmd_sel` into `wiper_code`. Opcode 011 copies `wiper_code` into preset `cmd_sel`, and this copy counts as a preset write.
- R6: After reset, `wiper_code` equals preset 0. Reset leaves the contents of all presets unchanged.
- R7: While `wp_n` is low, opcodes 111 and 011 change no preset and do not raise `busy`. Opcodes 101 and 010 still update the wiper code.
- R8: An accepted preset write holds `busy` high for exactly `NV_WRITE_CYCLES` cycles, starting on the accepting edge.
- R9: Any command presented while `busy` is high is dropped. It produces no `rd_valid` and changes neither the wiper code nor any preset.
- R10: Opcodes 000 and 001 have no effect. They produce no `rd_valid`, no `busy`, and no change to the wiper code or any preset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset; recalls preset 0 |
| cmd_valid | input | 1 | Command strobe, one cycle per command |
| cmd_op | input | 3 | Opcode (see R3 to R5, R10) |
| cmd_sel | input | 2 | Preset index |
| cmd_data | input | 10 | Write data |
| wp_n | input | 1 | Preset write enable; low blocks preset writes |
| busy | output | 1 | Write window in progress |
| rd_valid | output | 1 | One-cycle read response strobe |
| rd_data | output | 10 | Read response data |
| wiper_code | output | 10 | Current wiper code |
| tap_sel | output | 1024 | One-hot tap select |

## Verification
The wiper code is swept over all 1024 values. Each value is written, read back, and compared with an arithmetically shifted one-hot tap vector; the sweep separates decoder off-by-one and endpoint faults from write-path faults. Each preset is written with a distinct pattern and read back, which exposes index aliasing. The busy window is timed cycle by cycle, so an off-by-one in the timer shows up. Further sequences cover the protect input, commands issued during a busy window, the two unused opcodes, and a reset after a preset 0 update; these separate effects that are blocked from effects that are merely delayed.

// File: rtl/wb_pkg.sv
`timescale 1ns/1ps
package wb_pkg;
  localparam logic [2:0] OP_LOAD_WIPER = 3'b010;
  localparam logic [2:0] OP_SAVE_WIPER = 3'b011;
  localparam logic [2:0] OP_RD_WIPER   = 3'b100;
  localparam logic [2:0] OP_WR_WIPER   = 3'b101;
  localparam logic [2:0] OP_RD_PRESET  = 3'b110;
  localparam logic [2:0] OP_WR_PRESET  = 3'b111;
endpackage

// File: rtl/wb_nv_timer.sv
`timescale 1ns/1ps
module wb_nv_timer #(
  parameter int CYCLES = 250000
) (
  input  logic clk,
  input  logic rst,
  input  logic start,
  output logic busy
);
  localparam int CNTW = $clog2(CYCLES + 1);
  logic [CNTW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
      busy  <= 1'b0;
    end else if (start) begin
      cnt_q <= CNTW'(CYCLES);
      busy  <= 1'b1;
    end else if (cnt_q > CNTW'(1)) begin
      cnt_q <= cnt_q - 1'b1;
    end else begin
      cnt_q <= '0;
      busy  <= 1'b0;
    end
  end

  // R8
  start_busy_chk: assert property (@(posedge clk) disable iff (rst)
    start |=> busy);
  // R8
  hold_busy_chk: assert property (@(posedge clk) disable iff (rst)
    (busy && cnt_q > CNTW'(1)) |=> busy);
  // R9
  no_restart_chk: assert property (@(posedge clk) disable iff (rst)
    busy |-> !start);
endmodule

// File: rtl/wb_tap_decoder.sv
`timescale 1ns/1ps
module wb_tap_decoder #(
  parameter int CW = 10
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [CW-1:0]       code,
  output logic [(1<<CW)-1:0]  tap_sel
);
  localparam int NT = 1 << CW;

  for (genvar i = 0; i < NT; i++) begin : g_tap
    always_ff @(posedge clk) begin
      if (rst) tap_sel[i] <= (i == 0);
      else     tap_sel[i] <= (code == CW'(i));
    end
  end

  // R1
  one_tap_chk: assert property (@(posedge clk) disable iff (rst)
    $countones(tap_sel) == 1);
  // R1
  tap_follow_chk: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> tap_sel[$past(code)]);
  // R2
  low_end_chk: assert property (@(posedge clk) disable iff (rst)
    (code == '0) |=> tap_sel[0]);
  // R2
  high_end_chk: assert property (@(posedge clk) disable iff (rst)
    (code == '1) |=> tap_sel[NT-1]);
endmodule

// File: rtl/wb_regfile.sv
`timescale 1ns/1ps
module wb_regfile
  import wb_pkg::*;
#(
  parameter int          CW       = 10,
  parameter int          NDR      = 4,
  parameter logic [CW-1:0] INIT_DR0 = '0
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   cmd_valid,
  input  logic [2:0]             cmd_op,
  input  logic [$clog2(NDR)-1:0] cmd_sel,
  input  logic [CW-1:0]          cmd_data,
  input  logic                   wp_n,
  input  logic                   busy,
  output logic [CW-1:0]          wcr_q,
  output logic                   rd_valid,
  output logic [CW-1:0]          rd_data,
  output logic                   nv_start
);
  logic [CW-1:0] dr_q [NDR];
  logic          accept;
  logic          dr_req;
  logic [CW-1:0] dr_wdata;
  logic [CW-1:0] dr_rdata;

  initial begin
    for (int i = 0; i < NDR; i++) dr_q[i] = (i == 0) ? INIT_DR0 : '0;
  end

  always_comb begin
    accept   = cmd_valid && !busy;
    dr_req   = accept && (cmd_op == OP_WR_PRESET || cmd_op == OP_SAVE_WIPER);
    nv_start = dr_req && wp_n;
    dr_wdata = (cmd_op == OP_WR_PRESET) ? cmd_data : wcr_q;
    dr_rdata = dr_q[cmd_sel];
  end

  // Preset storage: not reset, so it survives reset like nonvolatile cells.
  always @(posedge clk) begin
    if (nv_start) dr_q[cmd_sel] <= dr_wdata;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wcr_q    <= dr_q[0];
      rd_valid <= 1'b0;
      rd_data  <= '0;
    end else begin
      rd_valid <= 1'b0;
      if (accept) begin
        case (cmd_op)
          OP_RD_WIPER:   begin rd_data <= wcr_q;    rd_valid <= 1'b1; end
          OP_RD_PRESET:  begin rd_data <= dr_rdata; rd_valid <= 1'b1; end
          OP_WR_WIPER:   wcr_q <= cmd_data;
          OP_LOAD_WIPER: wcr_q <= dr_rdata;
          default: ;
        endcase
      end
    end
  end

  // R9
  busy_drop_chk: assert property (@(posedge clk) disable iff (rst)
    (busy && cmd_valid) |=> (!rd_valid && $stable(wcr_q)));
endmodule

// File: rtl/wiper_bank.sv
`timescale 1ns/1ps
module wiper_bank
  import wb_pkg::*;
#(
  parameter int            CODE_W          = 10,
  parameter int            NUM_DR          = 4,
  parameter int            NV_WRITE_CYCLES = 250000,
  parameter logic [CODE_W-1:0] DR0_INIT    = 10'h200
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      cmd_valid,
  input  logic [2:0]                cmd_op,
  input  logic [$clog2(NUM_DR)-1:0] cmd_sel,
  input  logic [CODE_W-1:0]         cmd_data,
  input  logic                      wp_n,
  output logic                      busy,
  output logic                      rd_valid,
  output logic [CODE_W-1:0]         rd_data,
  output logic [CODE_W-1:0]         wiper_code,
  output logic [(1<<CODE_W)-1:0]    tap_sel
);
  logic nv_start;

  wb_regfile #(.CW(CODE_W), .NDR(NUM_DR), .INIT_DR0(DR0_INIT)) regs_i (
    .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
    .cmd_sel(cmd_sel), .cmd_data(cmd_data), .wp_n(wp_n), .busy(busy),
    .wcr_q(wiper_code), .rd_valid(rd_valid), .rd_data(rd_data),
    .nv_start(nv_start)
  );

  wb_nv_timer #(.CYCLES(NV_WRITE_CYCLES)) timer_i (
    .clk(clk), .rst(rst), .start(nv_start), .busy(busy)
  );

  wb_tap_decoder #(.CW(CODE_W)) dec_i (
    .clk(clk), .rst(rst), .code(wiper_code), .tap_sel(tap_sel)
  );

  // R3
  wiper_write_chk: assert property (@(posedge clk) disable iff (rst)
    (cmd_valid && !busy && cmd_op == OP_WR_WIPER) |=> wiper_code == $past(cmd_data));
  // R7
  protect_chk: assert property (@(posedge clk) disable iff (rst)
    (cmd_valid && !busy && !wp_n &&
     (cmd_op == OP_WR_PRESET || cmd_op == OP_SAVE_WIPER)) |=> !busy);
  // R10
  unused_op_chk: assert property (@(posedge clk) disable iff (rst)
    (cmd_valid && (cmd_op == 3'b000 || cmd_op == 3'b001))
      |=> ($stable(wiper_code) && !rd_valid));
endmodule

// File: tb/wiper_bank_tb.sv
`timescale 1ns/1ps
module wiper_bank_tb_top;
  localparam int W = 12;
  localparam logic [9:0] INIT0 = 10'h155;

  logic clk = 1'b0, rst = 1'b1, cmd_valid = 1'b0, wp_n = 1'b1;
  logic [2:0] cmd_op = '0;
  logic [1:0] cmd_sel = '0;
  logic [9:0] cmd_data = '0;
  logic busy, rd_valid;
  logic [9:0] rd_data, wiper_code;
  logic [1023:0] tap_sel;
  int checks = 0, fails = 0;
  logic [9:0] dv [4];

  wiper_bank #(.NV_WRITE_CYCLES(W), .DR0_INIT(INIT0)) dut_i (
    .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
    .cmd_sel(cmd_sel), .cmd_data(cmd_data), .wp_n(wp_n), .busy(busy),
    .rd_valid(rd_valid), .rd_data(rd_data), .wiper_code(wiper_code),
    .tap_sel(tap_sel)
  );

  always #2.5 clk = ~clk;

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic chk_tap(input string req, input int idx);
    logic [1023:0] exp;
    exp = 1024'(1) << idx;
    checks++;
    if (tap_sel !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, tap_sel, exp);
    end
  endtask

  task automatic cmd(input logic [2:0] op, input logic [1:0] sel, input logic [9:0] d);
    @(negedge clk);
    cmd_op = op; cmd_sel = sel; cmd_data = d; cmd_valid = 1'b1;
    @(negedge clk);
    cmd_valid = 1'b0;
  endtask

  task automatic wait_idle();
    while (busy) @(negedge clk);
  endtask

  task automatic rd_preset(input string req, input logic [1:0] sel, input logic [9:0] exp);
    cmd(3'b110, sel, 10'h0);
    chk(req, int'(rd_valid), 1);
    chk(req, int'(rd_data), int'(exp));
  endtask

  task automatic time_busy(input string req);
    int n = 0;
    while (busy && n < W + 5) begin n++; @(negedge clk); end
    chk(req, n, W);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    // R6 recall of preset 0 on reset
    chk("R6 recall", int'(wiper_code), int'(INIT0));
    chk("R8 idle after reset", int'(busy), 0);
    chk("R3 no read after reset", int'(rd_valid), 0);
    @(negedge clk);
    chk_tap("R1 tap after reset", int'(INIT0));

    // R1 R2 R3 full sweep of the wiper code
    for (int v = 0; v < 1024; v++) begin
      cmd(3'b101, 2'd0, v[9:0]);
      chk("R3 write wiper", int'(wiper_code), v);
      cmd(3'b100, 2'd0, 10'h0);
      chk("R3 read valid", int'(rd_valid), 1);
      chk("R3 read wiper", int'(rd_data), v);
      chk_tap("R1 one-hot tap", v);
      if (v == 0)    chk("R2 low terminal", int'(tap_sel[0]), 1);
      if (v == 1023) chk("R2 high terminal", int'(tap_sel[1023]), 1);
    end

    // R4 R8 preset writes with distinct patterns
    for (int k = 0; k < 4; k++) begin
      dv[k] = 10'((k * 293 + 17) ^ 10'h2A5);
      cmd(3'b111, 2'(k), dv[k]);
      time_busy("R8 busy window");
    end
    for (int k = 0; k < 4; k++) rd_preset("R4 preset readback", 2'(k), dv[k]);
    chk("R4 wiper untouched", int'(wiper_code), 1023);

    // R9 commands during busy are dropped
    cmd(3'b111, 2'd1, 10'h0AA);
    chk("R8 busy raised", int'(busy), 1);
    cmd(3'b100, 2'd0, 10'h0);
    chk("R9 read dropped", int'(rd_valid), 0);
    cmd(3'b101, 2'd0, 10'h011);
    chk("R9 wiper write dropped", int'(wiper_code), 1023);
    cmd(3'b111, 2'd2, 10'h001);
    wait_idle();
    dv[1] = 10'h0AA;
    rd_preset("R9 preset write dropped", 2'd2, dv[2]);
    rd_preset("R4 preset 1", 2'd1, dv[1]);

    // R5 transfers
    cmd(3'b010, 2'd2, 10'h0);
    chk("R5 preset to wiper", int'(wiper_code), int'(dv[2]));
    cmd(3'b101, 2'd0, 10'h2D4);
    cmd(3'b011, 2'd3, 10'h0);
    chk("R5 save raises busy", int'(busy), 1);
    time_busy("R8 save busy window");
    dv[3] = 10'h2D4;
    rd_preset("R5 wiper to preset", 2'd3, dv[3]);

    // R7 write protect
    wp_n = 1'b0;
    cmd(3'b111, 2'd3, 10'h0F0);
    chk("R7 no busy on blocked write", int'(busy), 0);
    rd_preset("R7 blocked write", 2'd3, dv[3]);
    cmd(3'b011, 2'd1, 10'h0);
    chk("R7 no busy on blocked save", int'(busy), 0);
    rd_preset("R7 blocked save", 2'd1, dv[1]);
    cmd(3'b101, 2'd0, 10'h123);
    chk("R7 wiper write allowed", int'(wiper_code), 'h123);
    cmd(3'b010, 2'd0, 10'h0);
    chk("R7 load allowed", int'(wiper_code), int'(dv[0]));
    cmd(3'b101, 2'd0, 10'h123);
    wp_n = 1'b1;

    // R10 unused opcodes
    for (int op = 0; op < 2; op++) begin
      cmd(3'(op), 2'd0, 10'h3FF);
      chk("R10 wiper unchanged", int'(wiper_code), 'h123);
      chk("R10 no read", int'(rd_valid), 0);
      chk("R10 no busy", int'(busy), 0);
      rd_preset("R10 preset unchanged", 2'd0, dv[0]);
    end

    // R6 recall after preset 0 update, presets kept
    cmd(3'b111, 2'd0, 10'h2A7);
    wait_idle();
    cmd(3'b101, 2'd0, 10'h00F);
    @(negedge clk); rst = 1'b1;
    repeat (2) @(negedge clk);
    rst = 1'b0;
    chk("R6 recall new preset 0", int'(wiper_code), 'h2A7);
    chk("R6 busy clear", int'(busy), 0);
    rd_preset("R6 preset 1 kept", 2'd1, dv[1]);
    rd_preset("R6 preset 3 kept", 2'd3, dv[3]);
    chk_tap("R1 tap after recall", 'h2A7);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    #(200000 * 5);
    checks++;
    fails++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule